// File: doc/BRIEF.md
# Two-Channel Segment-Count PWM Generator

This block produces two pulse-width-modulated outputs. Each channel builds its waveform from two separate segment lengths: a high segment followed by a low segment, each counted in ticks of that channel's own clock. The waveform repeats for as long as the channel runs. There is no compare against a single period counter. Each segment counter counts up to its own programmed length, and the two segments together form one period.

Each channel's clock is a tick stream. The channel picks one of four source tick inputs, which are strobes synchronous to `clk`. A 7-bit divider slows the chosen stream, and a gate lets it through. The block has one shared control word and one count word per channel, all reached through a plain word-wide register port. Writes take effect on the rising edge of `clk`. Reads are combinational from the address. The port has no handshake and no back-pressure. A write is accepted on every cycle in which `reg_we` is high.

Top module: `seg_pwm_top`

## Requirements
- R1: The register port decodes `reg_addr[3:2]`: 0 selects the channel-0 count word, 1 the channel-1 count word, 2 the control word, and 3 selects nothing. Address 3 reads as zero and ignores writes. Control bits 2, 3 and 24 to 31 always read as zero, and the other bits read back as written.
- R2: In a count word, bits 31:16 hold the high-segment length H and bits 15:0 the low-segment length L. A running channel with H≥1 and L≥1 is high for H channel ticks, then low for L channel ticks, and repeats.
- R3: In the control word, channel 0 uses bit 0 (enable), bits 5:4 (source select), bits 14:8 (divider) and bit 15 (gate). Channel 1 uses bit 1, bits 7:6, bits 22:16 and bit 23.
- R4: Source select value S makes the channel count pulses of `src_tick[S]`.
- R5: Divider value N produces one channel tick for every N+1 selected source pulses, so N=0 passes the source through unchanged.
- R6: A low length of 0 still gives one channel tick of low output per period, so the output is never constantly high.
- R7: A high length of 0 keeps the output low for the whole period.
- R8: The output is low whenever the channel's enable or gate is 0. Clearing either bit drives the output low on the cycle after the write, without finishing the current period.
- R9: When enable and gate both become 1 with H≥1, the output goes high on the cycle after the write and a new period begins.
- R10: A count word written while its channel runs does not change the current period. It takes effect from the next period.
- R11: Each channel's waveform depends only on its own fields and count word, whatever the other channel is doing.
- R12: After reset all registers read as zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| src_tick | input | 4 | Four source clock strobes, synchronous to `clk` |
| pwm_out | output | 2 | Waveform outputs, bit 0 for channel 0 |

## Verification
The hardest case to reach from the ports is a count word rewritten in the middle of a running period. The old segment lengths must finish before the new ones apply, and the only way to see this is the exact length of the high run that follows the write. The stimulus locks onto a rising edge of the output and writes new counts on the very next cycle. It then checks that the output stays high past the point where the new, shorter length would already have ended, and measures the next full period against the new lengths. The first period after each configuration change carries an unknown phase relation to the source strobes, so every randomized measurement throws away one period before it compares.

// File: rtl/seg_pwm_pkg.sv
package seg_pwm_pkg;
  localparam int NUM_CH    = 2;
  localparam int CNT_W     = 16;
  localparam int DIV_W     = 7;
  localparam int SEL_W     = 2;
  localparam int NUM_SRC   = 1 << SEL_W;
  localparam int WORD_W    = 32;
  localparam int SEL_LSB0  = 4;
  localparam int DIV_LSB0  = 8;
  localparam int GATE_BIT0 = 15;
  localparam int CH_STRIDE = 8;
  localparam logic [1:0] IDX_CNT0 = 2'd0;
  localparam logic [1:0] IDX_CNT1 = 2'd1;
  localparam logic [1:0] IDX_CTRL = 2'd2;
  localparam logic [WORD_W-1:0] CTRL_MASK = 32'h00FF_FFF3;

  typedef struct packed {
    logic             en;
    logic             gate;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } chan_cfg_t;

  function automatic chan_cfg_t ctrl_field(input logic [WORD_W-1:0] r, input int ch);
    chan_cfg_t f;
    f.en   = r[ch];
    f.sel  = r[SEL_LSB0 + SEL_W*ch +: SEL_W];
    f.div  = r[DIV_LSB0 + CH_STRIDE*ch +: DIV_W];
    f.gate = r[GATE_BIT0 + CH_STRIDE*ch];
    return f;
  endfunction
endpackage

// File: rtl/seg_pwm_regs.sv
module seg_pwm_regs
  import seg_pwm_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [3:0]                     addr,
  input  logic [WORD_W-1:0]              wdata,
  output logic [WORD_W-1:0]              rdata,
  output logic [NUM_CH-1:0][WORD_W-1:0]  count_q,
  output logic [WORD_W-1:0]              ctrl_q
);
  logic [1:0] idx;
  assign idx = addr[3:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      ctrl_q  <= '0;
    end else if (we) begin
      case (idx)
        IDX_CNT0: count_q[0] <= wdata;
        IDX_CNT1: count_q[1] <= wdata;
        IDX_CTRL: ctrl_q     <= wdata & CTRL_MASK;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_CNT0: rdata = count_q[0];
      IDX_CNT1: rdata = count_q[1];
      IDX_CTRL: rdata = ctrl_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/seg_pwm_clkdiv.sv
module seg_pwm_clkdiv #(
  parameter int NSRC = 4,
  parameter int SW   = 2,
  parameter int DW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic [SW-1:0]   sel,
  input  logic [DW-1:0]   div_n,
  input  logic            run,
  output logic            tick
);
  logic [DW-1:0] div_cnt;
  logic          sel_tick;
  logic          wrap;

  assign sel_tick = src_tick[sel];
  assign wrap     = (div_cnt >= div_n);
  assign tick     = run & sel_tick & wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)        div_cnt <= '0;
    else if (!run)     div_cnt <= '0;
    else if (sel_tick) div_cnt <= wrap ? '0 : div_cnt + 1'b1;
  end
endmodule

// File: rtl/seg_pwm_chan.sv
module seg_pwm_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] hi_cnt,
  input  logic [CW-1:0] lo_cnt,
  output logic          high_phase,
  output logic          period_end,
  output logic [CW-1:0] shadow_hi
);
  logic [CW-1:0] shadow_lo;
  logic [CW-1:0] elapsed;
  logic [CW:0]   next_cnt;
  logic [CW:0]   lo_eff;
  logic          hi_done;
  logic          lo_done;

  assign next_cnt   = {1'b0, elapsed} + (CW+1)'(1);
  assign lo_eff     = (shadow_lo == '0) ? (CW+1)'(1) : {1'b0, shadow_lo};
  assign hi_done    = next_cnt >= {1'b0, shadow_hi};
  assign lo_done    = next_cnt >= lo_eff;
  assign period_end = run & tick & ~high_phase & lo_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      high_phase <= 1'b0;
      elapsed    <= '0;
      shadow_hi  <= '0;
      shadow_lo  <= '0;
    end else if (!run) begin
      shadow_hi  <= hi_cnt;
      shadow_lo  <= lo_cnt;
      elapsed    <= '0;
      high_phase <= (hi_cnt != '0);
    end else if (tick) begin
      if (high_phase) begin
        if (hi_done) begin
          high_phase <= 1'b0;
          elapsed    <= '0;
        end else begin
          elapsed <= next_cnt[CW-1:0];
        end
      end else if (lo_done) begin
        shadow_hi  <= hi_cnt;
        shadow_lo  <= lo_cnt;
        elapsed    <= '0;
        high_phase <= (hi_cnt != '0);
      end else begin
        elapsed <= next_cnt[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/seg_pwm_top.sv
module seg_pwm_top
  import seg_pwm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [3:0]         reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic [NUM_CH-1:0]  pwm_out
);
  logic [NUM_CH-1:0][WORD_W-1:0] count_q;
  logic [WORD_W-1:0]             ctrl_q;
  logic [NUM_CH-1:0]             run;
  logic [NUM_CH-1:0]             ch_tick;
  logic [NUM_CH-1:0]             high_phase;
  logic [NUM_CH-1:0]             period_end;
  logic [NUM_CH-1:0][CNT_W-1:0]  shadow_hi;

  seg_pwm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .count_q (count_q),
    .ctrl_q  (ctrl_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_cfg_t cfg;
    assign cfg    = ctrl_field(ctrl_q, c);
    assign run[c] = cfg.en & cfg.gate;

    seg_pwm_clkdiv #(.NSRC(NUM_SRC), .SW(SEL_W), .DW(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .sel      (cfg.sel),
      .div_n    (cfg.div),
      .run      (run[c]),
      .tick     (ch_tick[c])
    );

    seg_pwm_chan #(.CW(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run[c]),
      .tick       (ch_tick[c]),
      .hi_cnt     (count_q[c][2*CNT_W-1:CNT_W]),
      .lo_cnt     (count_q[c][CNT_W-1:0]),
      .high_phase (high_phase[c]),
      .period_end (period_end[c]),
      .shadow_hi  (shadow_hi[c])
    );

    assign pwm_out[c] = run[c] & high_phase[c];
  end
endmodule

// File: rtl/seg_pwm_chk.sv
module seg_pwm_chk
  import seg_pwm_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_we,
  input logic [3:0]                    reg_addr,
  input logic [WORD_W-1:0]             reg_wdata,
  input logic [WORD_W-1:0]             ctrl_q,
  input logic [NUM_SRC-1:0]            src_tick,
  input logic [NUM_CH-1:0]             run,
  input logic [NUM_CH-1:0]             ch_tick,
  input logic [NUM_CH-1:0]             period_end,
  input logic [NUM_CH-1:0][CNT_W-1:0]  shadow_hi,
  input logic [NUM_CH-1:0]             pwm_out
);
  a_r1_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr[3:2] == IDX_CTRL) |=> (ctrl_q == ($past(reg_wdata) & CTRL_MASK)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R8: no channel tick while the channel is stopped
    a_r8_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tick[c] |-> run[c]);

    // R4: a channel tick only on a pulse of the selected source
    a_r4_tick_from_src: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tick[c] |-> src_tick[ctrl_field(ctrl_q, c).sel]);

    // R2: while running, the output moves only after a channel tick
    a_r2_out_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run[c]) && run[c] && !$past(ch_tick[c])) |-> $stable(pwm_out[c]));

    // R10: latched high length holds until the period ends
    a_r10_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run[c]) && run[c] && !$past(period_end[c])) |-> $stable(shadow_hi[c]));

    // R7: a zero high length never drives the output high
    a_r7_zero_high_low: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_hi[c] == '0) |-> !pwm_out[c]);
  end
endmodule

bind seg_pwm_top seg_pwm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .ctrl_q     (ctrl_q),
  .src_tick   (src_tick),
  .run        (run),
  .ch_tick    (ch_tick),
  .period_end (period_end),
  .shadow_hi  (shadow_hi),
  .pwm_out    (pwm_out)
);

// File: tb/seg_pwm_top_tb_top.sv
`timescale 1ns/1ps
module seg_pwm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  src_tick = '0;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  seg_pwm_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_tick(src_tick), .pwm_out(pwm_out)
  );

  // source strobe periods: 1, 2, 3, 5 cycles
  function automatic int src_per(input int s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return 5;
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    for (int s = 0; s < 4; s++) src_tick[s] <= (cyc % src_per(s)) == 0;
  end

  function automatic int exp_high(input int h, input int dv, input int sl);
    return h * (dv + 1) * src_per(sl);
  endfunction
  function automatic int exp_low(input int l, input int dv, input int sl);
    return ((l == 0) ? 1 : l) * (dv + 1) * src_per(sl);
  endfunction
  function automatic logic [31:0] mk_ctrl(input bit e0, input bit g0, input int s0, input int d0,
                                          input bit e1, input bit g1, input int s1, input int d1);
    logic [31:0] r = '0;
    r[0] = e0; r[1] = e1;
    r[5:4] = 2'(s0); r[7:6] = 2'(s1);
    r[14:8] = 7'(d0); r[22:16] = 7'(d1);
    r[15] = g0; r[23] = g1;
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // find a rising edge, then measure the high and low run lengths in cycles
  task automatic measure(input int ch, output int h, output int l);
    bit prev = pwm_out[ch];
    int guard = 0;
    h = 0; l = 0;
    while (guard < 5000) begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) break;
      prev = pwm_out[ch];
      guard++;
    end
    if (guard >= 5000) return;
    h = 1;
    while (h < 5000) begin
      @(negedge clk);
      if (pwm_out[ch]) h++; else break;
    end
    l = 1;
    while (l < 5000) begin
      @(negedge clk);
      if (!pwm_out[ch]) l++; else break;
    end
  endtask

  task automatic count_high(input int ch, input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) hits++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int h, l, hits;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(4'h0, d); chk("R12 cnt0 reset", int'(d), 0);
    rd(4'h4, d); chk("R12 cnt1 reset", int'(d), 0);
    rd(4'h8, d); chk("R12 ctrl reset", int'(d), 0);
    chk("R12 outputs low", int'(pwm_out), 0);

    // R1 register map
    wr(4'h0, 32'hABCD_1234); rd(4'h0, d); chk("R1 cnt0 readback", int'(d), int'(32'hABCD_1234));
    wr(4'h4, 32'h0102_0304); rd(4'h4, d); chk("R1 cnt1 readback", int'(d), int'(32'h0102_0304));
    wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, d); chk("R1 ctrl unused bits zero", int'(d), int'(32'h00FF_FFF3));
    wr(4'h8, 32'h0);
    wr(4'hC, 32'hFFFF_FFFF); rd(4'hC, d); chk("R1 addr 3 reads zero", int'(d), 0);
    rd(4'h0, d); chk("R1 addr 3 write ignored", int'(d), int'(32'hABCD_1234));

    // R2 R3 R4 R5 R11 randomized configs, both channels running
    for (int it = 0; it < 8; it++) begin
      int hh[2], ll[2], ss[2], dd[2];
      for (int c = 0; c < 2; c++) begin
        hh[c] = $urandom_range(1, 8); ll[c] = $urandom_range(0, 8);
        ss[c] = $urandom_range(0, 3); dd[c] = $urandom_range(0, 3);
      end
      wr(4'h8, 32'h0);
      wr(4'h0, {16'(hh[0]), 16'(ll[0])});
      wr(4'h4, {16'(hh[1]), 16'(ll[1])});
      wr(4'h8, mk_ctrl(1, 1, ss[0], dd[0], 1, 1, ss[1], dd[1]));
      for (int c = 0; c < 2; c++) begin
        measure(c, h, l);
        measure(c, h, l);
        chk($sformatf("R2 R4 R5 R11 ch%0d high", c), h, exp_high(hh[c], dd[c], ss[c]));
        chk($sformatf("R2 R3 R6 R11 ch%0d low", c), l, exp_low(ll[c], dd[c], ss[c]));
      end
    end

    // R6 zero low length: one tick low (sel 1, div 1 -> tick every 4 cycles)
    wr(4'h8, 32'h0);
    wr(4'h0, {16'd3, 16'd0});
    wr(4'h8, mk_ctrl(1, 1, 1, 1, 0, 0, 0, 0));
    measure(0, h, l); measure(0, h, l);
    chk("R6 high with zero low", h, 12);
    chk("R6 one tick low", l, 4);

    // R7 zero high length: never high
    wr(4'h8, 32'h0);
    wr(4'h0, {16'd0, 16'd5});
    wr(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    count_high(0, 200, hits);
    chk("R7 zero high stays low", hits, 0);

    // R8 gate off keeps output low; R9 gate on starts high at once
    wr(4'h8, 32'h0);
    wr(4'h0, {16'd6, 16'd3});
    wr(4'h8, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0));
    count_high(0, 50, hits);
    chk("R8 gate off low", hits, 0);
    wr(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    chk("R9 high on first cycle", int'(pwm_out[0]), 1);

    // R8 clearing enable in mid high phase drops output next cycle
    wr(4'h0, {16'd40, 16'd3});
    wr(4'h8, 32'h0);
    wr(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    repeat (5) @(negedge clk);
    chk("R8 high before disable", int'(pwm_out[0]), 1);
    wr(4'h8, mk_ctrl(0, 1, 0, 0, 0, 0, 0, 0));
    chk("R8 disable immediate", int'(pwm_out[0]), 0);

    // R10 counts rewritten mid-period apply from the next period
    wr(4'h0, {16'd6, 16'd3});
    wr(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    measure(0, h, l);
    begin
      bit prev = pwm_out[0];
      for (int g = 0; g < 200; g++) begin
        @(negedge clk);
        if (!prev && pwm_out[0]) break;
        prev = pwm_out[0];
      end
    end
    wr(4'h0, {16'd2, 16'd3});
    repeat (3) @(negedge clk);
    chk("R10 old high length kept", int'(pwm_out[0]), 1);
    measure(0, h, l);
    chk("R10 new high length", h, 2);
    chk("R10 new low length", l, 3);

    // R11 channel 1 unaffected by channel 0 being stopped
    wr(4'h8, 32'h0);
    wr(4'h4, {16'd4, 16'd2});
    wr(4'h8, mk_ctrl(0, 0, 0, 0, 1, 1, 2, 0));
    measure(1, h, l); measure(1, h, l);
    chk("R11 ch1 high alone", h, 12);
    chk("R11 ch1 low alone", l, 6);
    chk("R11 ch0 stays low", int'(pwm_out[0]), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule